// File: doc/BRIEF.md
# Processor Interrupt Input Conditioner

This block sits between a processor core and its board-level control pins. It takes in seven asynchronous pins: external interrupt, system management interrupt, machine check, checkstop, hard reset, soft reset and time base enable. It turns them into clean internal requests. Each pin is first brought into the core clock domain. The block then remembers the last level it accepted for that pin and reacts only when the level changes.

Three kinds of output come out of it:

- **Interrupts.** The interrupt pins become bits in a pending mask, and one combined request line is the OR of that mask. The core clears a bit it has serviced through a one-hot acknowledge port. This port is the only way to clear the machine check bit, because that bit is latched on an edge.
- **Core controls.** Checkstop drives a sticky halt. Hard reset gives a single-cycle system reset request.
- **Time base.** Time base enable starts and freezes a free-running time base counter.

The pin vector is wider than the defined set. Toggling any undefined pin position has no effect on the block.

Top module: `pin_conditioner`

## Requirements
- R1: A pin acts only when its synchronised level differs from the level last accepted for it. Holding a level produces no new event, so a pending bit that was acknowledged while its pin stays high remains clear.
- R2: External interrupt (pin 0), system management interrupt (pin 1) and soft reset (pin 5) are level sensitive. A rise sets pending bit 0, 1 or 3 respectively, and a fall clears it.
- R3: `irq_o` is high whenever any pending bit is set. It is low only when the whole pending mask is zero.
- R4: Machine check (pin 2) sets pending bit 2 only on a high-to-low transition. A low-to-high transition leaves it unchanged.
- R5: A one-hot `ack_i` clears the selected pending bit on the next clock edge. At most one `ack_i` bit may be high in a cycle.
- R6: A rise on checkstop (pin 3) sets `halt_o`. A later fall does not clear it; only reset does.
- R7: Each rise on hard reset (pin 4) gives `sysrst_req_o` high for exactly one cycle. Holding the pin high gives no further pulse.
- R8: A rise on time base enable (pin 6) sets `tb_run_o`, and a fall clears it. `tb_count_o` increments by one every cycle while `tb_run_o` is high and holds its value while it is low.
- R9: Pin positions 7 and above are undefined. Toggling them changes no output.
- R10: Reset clears all accepted levels, the pending mask, halt, the reset request, the time base run flag and the counter. A pin held high through reset is therefore seen as a rise afterwards.
- R11: A pin change reaches the outputs on the third rising clock edge after it is applied (two synchroniser stages plus one state stage). After two edges the outputs still show the old state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_PINS (8) | Asynchronous control pins, asserted level is 1 |
| ack_i | input | 4 | One-hot pending-bit acknowledge |
| irq_o | output | 1 | Combined interrupt request |
| pend_o | output | 4 | Pending mask: bit 0 ext, 1 smi, 2 machine check, 3 soft reset |
| halt_o | output | 1 | Sticky halt from checkstop |
| sysrst_req_o | output | 1 | One-cycle system reset request |
| tb_run_o | output | 1 | Time base running |
| tb_count_o | output | TB_W (64) | Time base counter value |

## Verification
The level pins are each driven through a full rise-and-fall cycle. These runs are checked one edge before and exactly on the expected edge, which separates the correct latency from an off-by-one pipeline.

Several further patterns each isolate one rule:

- Two pins overlap and are then released one at a time. This separates an OR of the pending mask from a tracker of the last event.
- Machine check is driven with the rising edge alone and then with the falling edge. This separates falling-edge capture from level capture.
- A pending bit is acknowledged while its pin is held high. This shows whether events come only from changes or from levels.

The remaining sequences cover the control outputs, undefined pins and reset. Checkstop is released and hard reset is held. The time base is started and stopped. Undefined pins are toggled. A pin is held high through reset.

// File: rtl/pinc_pkg.sv
package pinc_pkg;

    // Pin positions inside the pin vector.
    localparam int PIN_EXT      = 0;
    localparam int PIN_SMI      = 1;
    localparam int PIN_MCHK     = 2;
    localparam int PIN_CKSTOP   = 3;
    localparam int PIN_HRESET   = 4;
    localparam int PIN_SRESET   = 5;
    localparam int PIN_TBEN     = 6;
    localparam int DEFINED_PINS = 7;

    // Pending mask layout.
    localparam int PEND_EXT    = 0;
    localparam int PEND_SMI    = 1;
    localparam int PEND_MCHK   = 2;
    localparam int PEND_SRESET = 3;
    localparam int PEND_COUNT  = 4;

    typedef enum logic [1:0] {
        SENSE_LEVEL = 2'd0,
        SENSE_FALL  = 2'd1,
        SENSE_CTRL  = 2'd2
    } sense_e;

    typedef struct packed {
        logic halt;
        logic sysrst_req;
        logic tb_run;
    } core_ctl_t;

    // Which pin feeds a given pending bit.
    function automatic int pend_src(input int b);
        case (b)
            PEND_EXT:  return PIN_EXT;
            PEND_SMI:  return PIN_SMI;
            PEND_MCHK: return PIN_MCHK;
            default:   return PIN_SRESET;
        endcase
    endfunction

    // Sensitivity class of a defined pin.
    function automatic sense_e pin_sense(input int p);
        case (p)
            PIN_EXT, PIN_SMI, PIN_SRESET: return SENSE_LEVEL;
            PIN_MCHK:                     return SENSE_FALL;
            default:                      return SENSE_CTRL;
        endcase
    endfunction

endpackage

// File: rtl/pinc_sync.sv
module pinc_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/pinc_change.sv
module pinc_change
    import pinc_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] sync_i,
    output logic [NUM_PINS-1:0] rise_o,
    output logic [NUM_PINS-1:0] fall_o
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        if (i < DEFINED_PINS) begin : g_def
            logic level_q;

            always_ff @(posedge clk) begin
                if (rst) level_q <= 1'b0;
                else     level_q <= sync_i[i];
            end

            assign rise_o[i] = sync_i[i] & ~level_q;
            assign fall_o[i] = ~sync_i[i] & level_q;

            // R1
            no_double_rise_chk: assert property (@(posedge clk) disable iff (rst)
                rise_o[i] |=> !rise_o[i]);
        end else begin : g_undef
            logic unused_pin;
            assign unused_pin = sync_i[i];
            assign rise_o[i]  = 1'b0;
            assign fall_o[i]  = 1'b0;
        end
    end
endmodule

// File: rtl/pinc_pending.sv
module pinc_pending
    import pinc_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PINS-1:0]   rise_i,
    input  logic [NUM_PINS-1:0]   fall_i,
    input  logic [PEND_COUNT-1:0] ack_i,
    output logic [PEND_COUNT-1:0] pend_o
);
    logic [PEND_COUNT-1:0] pend_q;
    logic                  unused_ev;

    assign unused_ev = ^{rise_i, fall_i};

    for (genvar b = 0; b < PEND_COUNT; b++) begin : g_bit
        localparam int SRC = pend_src(b);
        logic set_w;
        logic clr_w;

        if (pin_sense(SRC) == SENSE_FALL) begin : g_fall
            assign set_w = fall_i[SRC];
            assign clr_w = ack_i[b];

            // R4
            mchk_rise_ignored_chk: assert property (@(posedge clk) disable iff (rst)
                (rise_i[SRC] && !pend_q[b] && !ack_i[b]) |=> !pend_q[b]);
        end else begin : g_level
            assign set_w = rise_i[SRC];
            assign clr_w = fall_i[SRC] | ack_i[b];

            // R2
            level_set_chk: assert property (@(posedge clk) disable iff (rst)
                rise_i[SRC] |=> pend_q[b]);
        end

        always_ff @(posedge clk) begin
            if (rst)        pend_q[b] <= 1'b0;
            else if (set_w) pend_q[b] <= 1'b1;
            else if (clr_w) pend_q[b] <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    // R5
    ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_i));
endmodule

// File: rtl/pinc_ctrl.sv
module pinc_ctrl
    import pinc_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int TB_W     = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] rise_i,
    input  logic [NUM_PINS-1:0] fall_i,
    output core_ctl_t           ctl_o,
    output logic [TB_W-1:0]     tb_count_o
);
    core_ctl_t       ctl_q;
    logic [TB_W-1:0] tb_cnt_q;
    logic            unused_ev;

    assign unused_ev = ^{rise_i, fall_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            tb_cnt_q <= '0;
        end else begin
            if (rise_i[PIN_CKSTOP]) ctl_q.halt <= 1'b1;
            ctl_q.sysrst_req <= rise_i[PIN_HRESET];
            if (rise_i[PIN_TBEN])      ctl_q.tb_run <= 1'b1;
            else if (fall_i[PIN_TBEN]) ctl_q.tb_run <= 1'b0;
            if (ctl_q.tb_run) tb_cnt_q <= tb_cnt_q + 1'b1;
        end
    end

    assign ctl_o      = ctl_q;
    assign tb_count_o = tb_cnt_q;

    // R6
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.halt |=> ctl_q.halt);

    // R7
    sysrst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.sysrst_req |=> !ctl_q.sysrst_req);

    // R8
    tb_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.tb_run |=> $stable(tb_cnt_q));

    // R8
    tb_step_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.tb_run |=> (tb_cnt_q == TB_W'($past(tb_cnt_q) + 1'b1)));
endmodule

// File: rtl/pin_conditioner.sv
module pin_conditioner
    import pinc_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int TB_W     = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PINS-1:0]   pins_i,
    input  logic [PEND_COUNT-1:0] ack_i,
    output logic                  irq_o,
    output logic [PEND_COUNT-1:0] pend_o,
    output logic                  halt_o,
    output logic                  sysrst_req_o,
    output logic                  tb_run_o,
    output logic [TB_W-1:0]       tb_count_o
);
    logic [NUM_PINS-1:0] sync_w;
    logic [NUM_PINS-1:0] rise_w;
    logic [NUM_PINS-1:0] fall_w;
    core_ctl_t           ctl_w;

    pinc_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pins_i),
        .sync_o  (sync_w)
    );

    pinc_change #(.NUM_PINS(NUM_PINS)) u_change (
        .clk    (clk),
        .rst    (rst),
        .sync_i (sync_w),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    pinc_pending #(.NUM_PINS(NUM_PINS)) u_pending (
        .clk    (clk),
        .rst    (rst),
        .rise_i (rise_w),
        .fall_i (fall_w),
        .ack_i  (ack_i),
        .pend_o (pend_o)
    );

    pinc_ctrl #(.NUM_PINS(NUM_PINS), .TB_W(TB_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rise_i     (rise_w),
        .fall_i     (fall_w),
        .ctl_o      (ctl_w),
        .tb_count_o (tb_count_o)
    );

    assign irq_o        = |pend_o;
    assign halt_o       = ctl_w.halt;
    assign sysrst_req_o = ctl_w.sysrst_req;
    assign tb_run_o     = ctl_w.tb_run;

    // R3
    irq_matches_mask_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o) |-> (pend_o == '0));
endmodule

// File: tb/pin_conditioner_tb.sv
module pin_conditioner_tb;
    localparam int NP = 8;
    localparam int TW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pins = '0;
    logic [3:0]    ack = '0;
    logic          irq, halt, sysrst, tb_run;
    logic [3:0]    pend;
    logic [TW-1:0] tb_count;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    pin_conditioner #(.NUM_PINS(NP), .TB_W(TW)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .pins_i       (pins),
        .ack_i        (ack),
        .irq_o        (irq),
        .pend_o       (pend),
        .halt_o       (halt),
        .sysrst_req_o (sysrst),
        .tb_run_o     (tb_run),
        .tb_count_o   (tb_count)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        waitn(2);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        pins = '0;
        do_reset();
        check("R10 pend", pend, 0);
        check("R10 irq", irq, 0);
        check("R10 halt", halt, 0);
        check("R10 sysrst", sysrst, 0);
        check("R10 tb_run", tb_run, 0);
        check("R10 tb_count", tb_count, 0);
    endtask

    task automatic t_level_pin(input int pin, input int bitn);
        pins[pin] = 1'b1;
        waitn(2);
        check("R11 before third edge", pend, 0);
        waitn(1);
        check("R2 level set", pend, 64'(1) << bitn);
        check("R3 irq up", irq, 1);
        pins[pin] = 1'b0;
        waitn(3);
        check("R2 level clear", pend, 0);
        check("R3 irq down", irq, 0);
    endtask

    task automatic t_irq_or();
        pins[0] = 1'b1;
        pins[1] = 1'b1;
        waitn(3);
        check("R3 two bits", pend, 4'b0011);
        pins[0] = 1'b0;
        waitn(3);
        check("R3 one left irq", irq, 1);
        pins[1] = 1'b0;
        waitn(3);
        check("R3 none left irq", irq, 0);
    endtask

    task automatic t_mchk();
        pins[2] = 1'b1;
        waitn(4);
        check("R4 rise ignored", pend, 0);
        pins[2] = 1'b0;
        waitn(3);
        check("R4 fall latched", pend, 4'b0100);
        waitn(4);
        check("R4 stays latched", pend, 4'b0100);
        ack = 4'b0100;
        waitn(1);
        ack = 4'b0000;
        check("R5 ack clears mchk", pend, 0);
        check("R5 irq after ack", irq, 0);
    endtask

    task automatic t_repeat();
        pins[0] = 1'b1;
        waitn(3);
        check("R1 set", pend, 4'b0001);
        ack = 4'b0001;
        waitn(1);
        ack = 4'b0000;
        check("R5 ack clears ext", pend, 0);
        waitn(6);
        check("R1 held level no event", pend, 0);
        pins[0] = 1'b0;
        waitn(3);
        pins[0] = 1'b1;
        waitn(3);
        check("R1 new change sets", pend, 4'b0001);
        pins[0] = 1'b0;
        waitn(3);
    endtask

    task automatic t_halt();
        pins[3] = 1'b1;
        waitn(3);
        check("R6 halt set", halt, 1);
        pins[3] = 1'b0;
        waitn(6);
        check("R6 halt sticky", halt, 1);
        do_reset();
        check("R10 halt cleared", halt, 0);
    endtask

    task automatic t_hreset();
        for (int rep = 0; rep < 2; rep++) begin
            pins[4] = 1'b1;
            waitn(2);
            check("R7 not yet", sysrst, 0);
            waitn(1);
            check("R7 pulse", sysrst, 1);
            waitn(1);
            check("R7 one cycle", sysrst, 0);
            waitn(4);
            check("R7 held no repeat", sysrst, 0);
            pins[4] = 1'b0;
            waitn(3);
        end
    endtask

    task automatic t_tb();
        logic [TW-1:0] c0;
        pins[6] = 1'b1;
        waitn(3);
        check("R8 run set", tb_run, 1);
        c0 = tb_count;
        waitn(5);
        check("R8 counts", tb_count, c0 + 5);
        pins[6] = 1'b0;
        waitn(3);
        check("R8 run clear", tb_run, 0);
        c0 = tb_count;
        waitn(6);
        check("R8 frozen", tb_count, c0);
    endtask

    task automatic t_undef();
        logic [TW+7:0] snap;
        snap = {irq, pend, halt, sysrst, tb_run, tb_count};
        pins[7] = 1'b1;
        waitn(5);
        check("R9 undefined high", {irq, pend, halt, sysrst, tb_run, tb_count} == snap, 1);
        pins[7] = 1'b0;
        waitn(5);
        check("R9 undefined low", {irq, pend, halt, sysrst, tb_run, tb_count} == snap, 1);
    endtask

    task automatic t_reset_edge();
        pins[5] = 1'b1;
        do_reset();
        check("R10 cleared in reset", pend, 0);
        waitn(2);
        check("R11 post-reset latency", pend, 0);
        waitn(1);
        check("R10 held pin seen", pend, 4'b1000);
        pins[5] = 1'b0;
        waitn(3);
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_level_pin(0, 0);
        t_level_pin(1, 1);
        t_level_pin(5, 3);
        t_irq_or();
        t_mchk();
        t_repeat();
        t_hreset();
        t_tb();
        t_undef();
        t_halt();
        t_reset_edge();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule